// File: doc/BRIEF.md
# Acquisition Sample FIFO with Interrupt and Trigger Control

This block sits between an ADC scan sequencer and a host register bus. Converted samples, each carrying a channel tag in its upper bits, come in on a valid-qualified stream and are queued in a first-in first-out buffer. The host pops them one at a time by reading the data register. A status word reports empty, half-full and full, plus an interrupt-pending flag. The flag is raised either on every accepted sample or once each time the fill level reaches half the buffer.

A control word enables the conversion trigger sources: a software strobe, a pacer tick from a counter outside the block, and an external trigger pin. The external pin passes through two synchroniser flops and an edge detector before use. Its synchronised level can also gate the pacer ticks. The selected triggers are merged into a single `conv_start` pulse for the sequencer. Two write-only strobe addresses empty the buffer and drop the pending flag.

The sample input has no ready signal, so the block never applies back-pressure. The source may assert `smp_valid` in any cycle. A sample offered while the buffer holds `DEPTH` entries is discarded. The default build has 64 entries. A 4096-entry build gives the 2048-sample half-full threshold.

Top module: `acq_fifo_irq`

## Requirements
- R1: After reset the status word reads 0x0100 (only the empty bit, bit 8, set), the control word is zero, and `irq`, `conv_start` and `cnt_clk_ext` are low.
- R2: Samples are returned in arrival order. Each read of register address 0 returns the oldest sample and removes it.
- R3: A read of address 0 while the buffer is empty returns zero and leaves the buffer unchanged. The next sample pushed is the next one returned.
- R4: Status bit 9 (half full) is set while at least DEPTH/2 samples are held. Status bit 10 (full) is set when DEPTH samples are held.
- R5: A sample offered while DEPTH samples are held is discarded. Once set, the full bit stays set, even after samples are read, until the buffer is cleared.
- R6: A write to address 3 empties the buffer and clears the full bit. A clear in the same cycle as an incoming sample wins.
- R7: With control bit 5 clear, every accepted sample sets the pending flag (status bit 11). A write to address 2 clears the flag, but a new event in the same cycle keeps it set.
- R8: With control bit 5 set, the pending flag is set only in the cycle the fill level rises to DEPTH/2. Samples below or above that level do not set it.
- R9: `irq` is the pending flag qualified by control bit 4. The flag is still set by events while bit 4 is clear.
- R10: A write of any value to address 0 produces one `conv_start` pulse in the next cycle when control bit 0 is set, and no pulse otherwise.
- R11: A `pacer_tick` produces one `conv_start` pulse when control bit 1 is set. If control bit 3 is also set, the pulse occurs only while the synchronised external pin is high.
- R12: With control bit 2 set, each rising edge on `ext_trig` produces exactly one `conv_start` pulse after two synchroniser stages. Holding the pin high produces no further pulses.
- R13: Writes to address 1 load control bits 6:0. Reads of address 1 return them in status bits 6:0. Control bit 6 drives `cnt_clk_ext`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample present on `smp_data` this cycle |
| smp_data | input | DATA_W | Tagged ADC sample |
| reg_addr | input | 2 | Register address: 0 data/strobe, 1 control/status, 2 clear interrupt, 3 clear buffer |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at address 0) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| pacer_tick | input | 1 | Tick from the external pacer counter |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| conv_start | output | 1 | One-cycle conversion start to the scan sequencer |
| cnt_clk_ext | output | 1 | Counter clock source select (control bit 6) |
| irq | output | 1 | Interrupt request |

## Verification
The buffer is driven with short tagged sequences that expose ordering errors. It is also filled exactly to one below half, to half, to full and one beyond. This separates an off-by-one threshold, a wrapped pointer and a dropped or overwritten overflow sample. Reads of an empty buffer followed by a push show whether pointers moved. Both interrupt modes run with the interrupt enable on and off, which separates the pending flag from the output gating. Each trigger source is pulsed with its enable on and off. The pacer is also tried under the gate with the pin low and high, and the external pin is held high to catch level-sensitive triggering.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 16;

  localparam logic [REG_AW-1:0] A_DATA   = 2'd0;
  localparam logic [REG_AW-1:0] A_CTRL   = 2'd1;
  localparam logic [REG_AW-1:0] A_CLRIRQ = 2'd2;
  localparam logic [REG_AW-1:0] A_CLRBUF = 2'd3;

  localparam int CTL_W     = 7;
  localparam int C_SW      = 0;
  localparam int C_PACER   = 1;
  localparam int C_EXT     = 2;
  localparam int C_GATE    = 3;
  localparam int C_IRQEN   = 4;
  localparam int C_HALFIRQ = 5;
  localparam int C_CLKSEL  = 6;

  localparam int S_EMPTY = 8;
  localparam int S_HALF  = 9;
  localparam int S_FULL  = 10;
  localparam int S_PEND  = 11;
endpackage

// File: rtl/acq_edge_sync.sv
module acq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/acq_sample_fifo.sv
module acq_sample_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              half,
  output logic              full_hold,
  output logic              pushed,
  output logic              half_rise
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     level_q, level_nx;
  logic              do_pop;

  assign pushed = push && !clr && (level_q != LVL_FULL);
  assign do_pop = pop && !clr && (level_q != '0);

  always_comb begin
    level_nx = level_q;
    if (clr)                     level_nx = '0;
    else if (pushed && !do_pop)  level_nx = level_q + 1'b1;
    else if (!pushed && do_pop)  level_nx = level_q - 1'b1;
  end

  assign half_rise = (level_q < LVL_HALF) && (level_nx >= LVL_HALF);

  always_ff @(posedge clk) begin
    if (pushed) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level_q   <= '0;
      full_hold <= 1'b0;
    end else begin
      if (pushed) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      level_q   <= level_nx;
      full_hold <= full_hold | (level_nx == LVL_FULL);
    end
  end

  assign empty = (level_q == '0);
  assign half  = (level_q >= LVL_HALF);
  assign head  = empty ? '0 : mem[rd_ptr];
endmodule

// File: rtl/acq_irq_ctrl.sv
module acq_irq_ctrl
  import acq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [CTL_W-1:0] ctrl_wdata,
  input  logic             sw_strobe,
  input  logic             pacer_tick,
  input  logic             ext_level,
  input  logic             ext_rise,
  input  logic             smp_evt,
  input  logic             half_evt,
  input  logic             clr_irq,
  output logic [CTL_W-1:0] ctrl,
  output logic             evt,
  output logic             pend,
  output logic             conv_start
);
  logic pacer_ok;

  assign pacer_ok = pacer_tick && ctrl[C_PACER] && (!ctrl[C_GATE] || ext_level);
  assign evt      = ctrl[C_HALFIRQ] ? half_evt : smp_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl       <= '0;
      pend       <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      if (ctrl_we) ctrl <= ctrl_wdata;
      if (evt)          pend <= 1'b1;
      else if (clr_irq) pend <= 1'b0;
      conv_start <= (sw_strobe && ctrl[C_SW]) || pacer_ok || (ext_rise && ctrl[C_EXT]);
    end
  end
endmodule

// File: rtl/acq_fifo_irq.sv
module acq_fifo_irq
  import acq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              pacer_tick,
  input  logic              ext_trig,
  output logic              conv_start,
  output logic              cnt_clk_ext,
  output logic              irq
);
  logic [DATA_W-1:0] head;
  logic              fifo_empty, fifo_half, fifo_full, pushed, half_rise;
  logic              ext_level, ext_rise;
  logic [CTL_W-1:0]  ctrl_q;
  logic              pend_q, irq_evt;
  logic              wr_data, wr_ctrl, wr_clrirq, wr_clrbuf, rd_data;
  logic [15:0]       status;

  assign wr_data   = reg_wr && (reg_addr == A_DATA);
  assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
  assign wr_clrirq = reg_wr && (reg_addr == A_CLRIRQ);
  assign wr_clrbuf = reg_wr && (reg_addr == A_CLRBUF);
  assign rd_data   = reg_rd && (reg_addr == A_DATA);

  acq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_trig),
    .level(ext_level), .rise(ext_rise)
  );

  acq_sample_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(wr_clrbuf),
    .push(smp_valid), .push_data(smp_data), .pop(rd_data),
    .head(head), .empty(fifo_empty), .half(fifo_half),
    .full_hold(fifo_full), .pushed(pushed), .half_rise(half_rise)
  );

  acq_irq_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(wr_ctrl), .ctrl_wdata(reg_wdata[CTL_W-1:0]),
    .sw_strobe(wr_data), .pacer_tick(pacer_tick),
    .ext_level(ext_level), .ext_rise(ext_rise),
    .smp_evt(pushed), .half_evt(half_rise), .clr_irq(wr_clrirq),
    .ctrl(ctrl_q), .evt(irq_evt), .pend(pend_q), .conv_start(conv_start)
  );

  always_comb begin
    status = '0;
    status[CTL_W-1:0] = ctrl_q;
    status[S_EMPTY]   = fifo_empty;
    status[S_HALF]    = fifo_half;
    status[S_FULL]    = fifo_full;
    status[S_PEND]    = pend_q;
  end

  generate
    if (DATA_W >= 16) begin : g_wide
      assign reg_rdata = (reg_addr == A_CTRL) ? status :
                         (reg_addr == A_DATA) ? head[15:0] : 16'h0;
    end else begin : g_narrow
      assign reg_rdata = (reg_addr == A_CTRL) ? status :
                         (reg_addr == A_DATA) ? {{(16-DATA_W){1'b0}}, head} : 16'h0;
    end
  endgenerate

  assign cnt_clk_ext = ctrl_q[C_CLKSEL];
  assign irq         = pend_q && ctrl_q[C_IRQEN];
endmodule

// File: rtl/acq_fifo_irq_chk.sv
module acq_fifo_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_addr,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic       smp_valid,
  input logic       conv_start,
  input logic       irq,
  input logic [6:0] ctrl_q,
  input logic       pend_q,
  input logic       irq_evt,
  input logic       fifo_empty,
  input logic       fifo_full
);
  // R9: output never raised while the enable bit is clear
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[4] |-> !irq);

  // R6: a clear-buffer write leaves the buffer empty and not full
  p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3) |=> (fifo_empty && !fifo_full));

  // R5: full stays set until a clear-buffer write
  p_full_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !(reg_wr && reg_addr == 2'd3)) |=> fifo_full);

  // R3: a read of an empty buffer with no incoming sample leaves it empty
  p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && reg_rd && reg_addr == 2'd0 && !smp_valid) |=> fifo_empty);

  // R7: clear-interrupt without a concurrent event drops the flag
  p_clear_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && !irq_evt) |=> !pend_q);

  // R7: an event always leaves the flag set
  p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |=> pend_q);

  // R10: a start pulse needs at least one source enabled in the prior cycle
  p_start_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(ctrl_q[0] || ctrl_q[1] || ctrl_q[2]));
endmodule

bind acq_fifo_irq acq_fifo_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .smp_valid(smp_valid), .conv_start(conv_start),
  .irq(irq), .ctrl_q(ctrl_q), .pend_q(pend_q), .irq_evt(irq_evt),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full)
);

// File: tb/sim_acq_fifo_irq.sv
`timescale 1ns/1ps
module sim_acq_fifo_irq;
  localparam int DEPTH = 64;
  localparam int HALF  = DEPTH / 2;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        smp_valid = 0;
  logic [15:0] smp_data = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pacer_tick = 0, ext_trig = 0;
  logic        conv_start, cnt_clk_ext, irq;

  int errors = 0, checks = 0, pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  acq_fifo_irq #(.DATA_W(16), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pacer_tick(pacer_tick), .ext_trig(ext_trig),
    .conv_start(conv_start), .cnt_clk_ext(cnt_clk_ext), .irq(irq)
  );

  always @(negedge clk) if (conv_start) pulses++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic status(output logic [15:0] s);
    @(negedge clk); reg_addr = 2'd1; #1 s = reg_rdata;
  endtask

  task automatic push(logic [15:0] d);
    @(negedge clk); smp_valid = 1; smp_data = d;
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic t_reset();
    logic [15:0] s;
    status(s);
    check("R1 status", s, 16'h0100);
    check("R1 outputs", {irq, conv_start, cnt_clk_ext}, 3'b000);
  endtask

  task automatic t_order();
    logic [15:0] d;
    push(16'h1abc); push(16'h2def); push(16'h3123);
    rd(0, d); check("R2 first", d, 16'h1abc);
    rd(0, d); check("R2 second", d, 16'h2def);
    rd(0, d); check("R2 third", d, 16'h3123);
    status(d); check("R2 empty after pops", d[10:8], 3'b001);
  endtask

  task automatic t_empty_read();
    logic [15:0] d;
    rd(0, d); check("R3 empty read", d, 16'h0);
    rd(0, d);
    push(16'h4555);
    rd(0, d); check("R3 pointer kept", d, 16'h4555);
  endtask

  task automatic t_fill();
    logic [15:0] d;
    wr(3, 0);
    for (int i = 0; i < HALF - 1; i++) push(16'(i));
    status(d); check("R4 below half", d[10:8], 3'b000);
    push(16'(HALF - 1));
    status(d); check("R4 at half", d[10:8], 3'b010);
    for (int i = HALF; i < DEPTH; i++) push(16'(i));
    status(d); check("R4 full", d[10:8], 3'b110);
    push(16'hffff);
    rd(0, d); check("R5 oldest kept", d, 16'h0);
    status(d); check("R5 full sticky", d[10], 1'b1);
    for (int i = 1; i < DEPTH - 1; i++) rd(0, d);
    rd(0, d); check("R5 overflow dropped", d, 16'(DEPTH - 1));
    status(d); check("R5 empty but full", d[10:8], 3'b101);
    wr(3, 0);
    status(d); check("R6 clear full", d[10:8], 3'b001);
    push(16'h5001); push(16'h5002);
    wr(3, 0);
    rd(0, d); check("R6 cleared data", d, 16'h0);
  endtask

  task automatic t_irq_sample();
    logic [15:0] d;
    wr(1, 16'h0010); wr(2, 0);
    status(d); check("R7 pending cleared", d[11], 1'b0);
    push(16'h6001);
    status(d); check("R7 pending on sample", d[11], 1'b1);
    check("R9 irq enabled", irq, 1'b1);
    wr(2, 0);
    check("R7 clear drops irq", irq, 1'b0);
    wr(1, 16'h0000);
    push(16'h6002);
    status(d); check("R9 pending while disabled", d[11], 1'b1);
    check("R9 irq masked", irq, 1'b0);
  endtask

  task automatic t_irq_half();
    logic [15:0] d;
    wr(3, 0); wr(1, 16'h0030); wr(2, 0);
    for (int i = 0; i < HALF - 1; i++) push(16'(i));
    status(d); check("R8 no pending below half", d[11], 1'b0);
    push(16'h7777);
    status(d); check("R8 pending at half", d[11], 1'b1);
    check("R8 irq at half", irq, 1'b1);
    wr(2, 0); push(16'h7778);
    status(d); check("R8 none above half", d[11], 1'b0);
    wr(3, 0);
  endtask

  task automatic t_sw();
    int p0;
    wr(1, 16'h0000); p0 = pulses; wr(0, 16'h1234);
    @(negedge clk); check("R10 disabled", pulses - p0, 0);
    wr(1, 16'h0001); p0 = pulses; wr(0, 16'h0);
    @(negedge clk); check("R10 enabled", pulses - p0, 1);
  endtask

  task automatic tick();
    @(negedge clk); pacer_tick = 1;
    @(negedge clk); pacer_tick = 0;
    @(negedge clk);
  endtask

  task automatic t_pacer();
    int p0;
    wr(1, 16'h0002); p0 = pulses; tick();
    check("R11 pacer enabled", pulses - p0, 1);
    wr(1, 16'h0000); p0 = pulses; tick();
    check("R11 pacer disabled", pulses - p0, 0);
    wr(1, 16'h000a); p0 = pulses; tick();
    check("R11 gate low", pulses - p0, 0);
    ext_trig = 1; repeat (4) @(negedge clk);
    p0 = pulses; tick();
    check("R11 gate high", pulses - p0, 1);
    ext_trig = 0; repeat (4) @(negedge clk);
  endtask

  task automatic t_ext();
    int p0;
    wr(1, 16'h0004); p0 = pulses;
    ext_trig = 1; repeat (6) @(negedge clk);
    check("R12 one pulse", pulses - p0, 1);
    repeat (6) @(negedge clk);
    check("R12 level ignored", pulses - p0, 1);
    ext_trig = 0; repeat (4) @(negedge clk);
    wr(1, 16'h0000); p0 = pulses;
    ext_trig = 1; repeat (6) @(negedge clk);
    check("R12 disabled", pulses - p0, 0);
    ext_trig = 0; repeat (4) @(negedge clk);
  endtask

  task automatic t_ctrl();
    logic [15:0] d;
    wr(1, 16'h0040);
    status(d); check("R13 echo", d[6:0], 7'h40);
    check("R13 clock select", cnt_clk_ext, 1'b1);
    wr(1, 16'h0000);
    check("R13 clock select off", cnt_clk_ext, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_empty_read();
    t_fill();
    t_irq_sample();
    t_irq_half();
    t_sw();
    t_pacer();
    t_ext();
    t_ctrl();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule